// File: doc/BRIEF.md
# Double-Buffered Segment Display Mode Engine

This block holds the pixel pattern for a segment display. It supports up to six common lines and fifty segment lines. Software-side logic writes pattern words into a user buffer. At each frame-end strobe the user buffer is copied into a display buffer. For the common line the drive sequencer currently selects, the engine returns that line's segment pattern after the chosen display mode has been applied. It then masks the pattern with a per-segment enable map.

There are eight display modes: latched, blank, fill, blink, inverted, inverted blink, freeze and swap. Freeze stops the frame-end copy. Swap alternates the visible pattern between the two buffers. No mode ever changes the contents of either buffer. Frame timing and the analog drive levels are generated elsewhere and reach the block only as the frame-end strobe and the common select.

A programmable blink period sets how many frames pass between toggles of the blink phase. The blink, inverted-blink and swap modes all use that phase.

Top module: `lcd_mode_engine`

## Requirements
- R1: After reset, both buffers hold zero, phase_o is 1 and seg_o is all zero for every common select.
- R2: A write with wr_hi_i=0 loads wr_data_i[31:0] into segments 31..0 of common wr_com_i. A write with wr_hi_i=1 loads wr_data_i[17:0] into segments 49..32. A write to a common index of 6 or 7 changes nothing.
- R3: On a frame_end_i cycle in any mode other than 6, every common's user row is copied to its display row. Mode 0 (latched) shows the display row, so a newly written pattern appears only after the next frame end.
- R4: Mode 6 (freeze) shows the display row and suppresses the frame-end copy.
- R5: Mode 1 (blank) drives every segment to 0. Mode 2 (fill) drives every mapped segment to 1.
- R6: Mode 4 (invert) shows the bitwise inverse of the display row.
- R7: The blink phase toggles at every (blink_per_i+1)-th frame end. The toggle fires when the internal frame count is at or above blink_per_i, and the count then restarts. A blink_per_i of 0 forces the phase to 1 at each frame end. The phase changes only on frame_end_i cycles.
- R8: Mode 3 (blink) shows the display row while phase_o=1 and zero while phase_o=0. Mode 5 (inverted blink) shows the inverted display row while phase_o=1 and zero while phase_o=0.
- R9: Mode 7 (swap) shows the display row while phase_o=1 and the user row while phase_o=0.
- R10: A segment whose seg_map_i bit is 0 outputs 0. A com_sel_i of 6 or 7 outputs all zero.
- R11: Display modes never alter stored data. After modes 1, 2 and 4, returning to mode 0 shows the prior pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | User buffer write strobe |
| wr_com_i | input | 3 | Common index for the write |
| wr_hi_i | input | 1 | 1 selects the segment 49..32 word |
| wr_data_i | input | 32 | Write data |
| seg_map_i | input | 50 | Per-segment drive enable |
| mode_i | input | 3 | Display mode, 0..7 |
| blink_per_i | input | 8 | Frames per blink phase, minus one |
| frame_end_i | input | 1 | Frame-end strobe |
| com_sel_i | input | 3 | Common currently being driven |
| seg_o | output | 50 | Segment pattern for com_sel_i |
| phase_o | output | 1 | Blink phase, 1 = visible |

## Verification
The assertions assume that frame_end_i is a single-cycle strobe. They also assume that mode_i and blink_per_i are sampled on the frame-end cycle, so the copy and the phase update follow the mode that is present on that edge. The stimulus drives every input on the falling edge and holds it for whole cycles. Writes and frame ends are issued in separate cycles. Mode, period and map changes are applied between strobes, so the bench model always sees the same ordering as the design.

// File: rtl/lcd_mode_pkg.sv
package lcd_mode_pkg;
  typedef enum logic [2:0] {
    MD_LATCHED   = 3'd0,
    MD_BLANK     = 3'd1,
    MD_FILL      = 3'd2,
    MD_BLINK     = 3'd3,
    MD_INVERT    = 3'd4,
    MD_INV_BLINK = 3'd5,
    MD_FREEZE    = 3'd6,
    MD_SWAP      = 3'd7
  } lcd_mode_e;
endpackage

// File: rtl/lcd_pix_store.sv
module lcd_pix_store #(
  parameter int N_COM = 6,
  parameter int N_SEG = 50,
  parameter int LO_W  = 32,
  parameter int COM_W = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [COM_W-1:0]                  wr_com_i,
  input  logic                              wr_hi_i,
  input  logic [LO_W-1:0]                   wr_data_i,
  input  logic                              copy_i,
  output logic [N_COM-1:0][N_SEG-1:0]       user_o,
  output logic [N_COM-1:0][N_SEG-1:0]       disp_o
);
  localparam int HI_W = N_SEG - LO_W;

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    logic hit;
    assign hit = wr_en_i && (wr_com_i == COM_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        user_o[c] <= '0;
      end else if (hit) begin
        if (wr_hi_i) user_o[c][N_SEG-1:LO_W] <= wr_data_i[HI_W-1:0];
        else         user_o[c][LO_W-1:0]     <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     disp_o[c] <= '0;
      else if (copy_i) disp_o[c] <= user_o[c];
    end
  end
endmodule

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [BW-1:0] period_i,
  output logic          phase_o
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (tick_i) begin
      if (period_i == '0) begin
        cnt_q   <= '0;
        phase_o <= 1'b1;
      end else if (cnt_q >= period_i) begin
        // >= so a shrunk period never waits for a counter wrap
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_mode_mux.sv
module lcd_mode_mux
  import lcd_mode_pkg::*;
#(
  parameter int N_SEG = 50
) (
  input  lcd_mode_e          mode_i,
  input  logic               phase_i,
  input  logic               valid_i,
  input  logic [N_SEG-1:0]   user_i,
  input  logic [N_SEG-1:0]   disp_i,
  input  logic [N_SEG-1:0]   map_i,
  output logic [N_SEG-1:0]   seg_o
);
  logic [N_SEG-1:0] pat;

  always_comb begin
    unique case (mode_i)
      MD_LATCHED, MD_FREEZE: pat = disp_i;
      MD_BLANK:              pat = '0;
      MD_FILL:               pat = '1;
      MD_BLINK:              pat = phase_i ? disp_i : '0;
      MD_INVERT:             pat = ~disp_i;
      MD_INV_BLINK:          pat = phase_i ? ~disp_i : '0;
      MD_SWAP:               pat = phase_i ? disp_i : user_i;
      default:               pat = '0;
    endcase
    seg_o = valid_i ? (pat & map_i) : '0;
  end
endmodule

// File: rtl/lcd_mode_engine.sv
module lcd_mode_engine
  import lcd_mode_pkg::*;
#(
  parameter int N_COM = 6,
  parameter int N_SEG = 50,
  parameter int LO_W  = 32,
  parameter int BW    = 8,
  parameter int COM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [COM_W-1:0]  wr_com_i,
  input  logic              wr_hi_i,
  input  logic [LO_W-1:0]   wr_data_i,
  input  logic [N_SEG-1:0]  seg_map_i,
  input  logic [2:0]        mode_i,
  input  logic [BW-1:0]     blink_per_i,
  input  logic              frame_end_i,
  input  logic [COM_W-1:0]  com_sel_i,
  output logic [N_SEG-1:0]  seg_o,
  output logic              phase_o
);
  lcd_mode_e                    mode;
  logic                         copy;
  logic                         com_ok;
  logic [N_COM-1:0][N_SEG-1:0]  user_q;
  logic [N_COM-1:0][N_SEG-1:0]  disp_q;
  logic [N_SEG-1:0]             user_row;
  logic [N_SEG-1:0]             disp_row;

  assign mode = lcd_mode_e'(mode_i);
  assign copy = frame_end_i && (mode != MD_FREEZE);

  lcd_pix_store #(
    .N_COM(N_COM), .N_SEG(N_SEG), .LO_W(LO_W), .COM_W(COM_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_com_i (wr_com_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .copy_i   (copy),
    .user_o   (user_q),
    .disp_o   (disp_q)
  );

  lcd_blink_timer #(.BW(BW)) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (frame_end_i),
    .period_i(blink_per_i),
    .phase_o (phase_o)
  );

  always_comb begin
    com_ok   = 1'b0;
    user_row = '0;
    disp_row = '0;
    for (int c = 0; c < N_COM; c++) begin
      if (com_sel_i == COM_W'(c)) begin
        com_ok   = 1'b1;
        user_row = user_q[c];
        disp_row = disp_q[c];
      end
    end
  end

  lcd_mode_mux #(.N_SEG(N_SEG)) u_mux (
    .mode_i (mode),
    .phase_i(phase_o),
    .valid_i(com_ok),
    .user_i (user_row),
    .disp_i (disp_row),
    .map_i  (seg_map_i),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/lcd_mode_engine_chk.sv
module lcd_mode_engine_chk #(
  parameter int N_COM = 6,
  parameter int N_SEG = 50,
  parameter int BW    = 8
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [2:0]                       mode_i,
  input logic [BW-1:0]                    blink_per_i,
  input logic                             frame_end_i,
  input logic [N_SEG-1:0]                 seg_map_i,
  input logic [N_SEG-1:0]                 seg_o,
  input logic                             phase_o,
  input logic [N_COM-1:0][N_SEG-1:0]      user_q,
  input logic [N_COM-1:0][N_SEG-1:0]      disp_q
);
  // R7
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && blink_per_i == '0) |=> phase_o);

  // R7
  phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(phase_o));

  // R3
  frame_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && mode_i != 3'd6) |=> (disp_q == $past(user_q)));

  // R4
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && mode_i == 3'd6) |=> $stable(disp_q));

  // R10
  map_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o & ~seg_map_i) == '0);

  // R5
  blank_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1) |-> (seg_o == '0));
endmodule

bind lcd_mode_engine lcd_mode_engine_chk #(
  .N_COM(N_COM), .N_SEG(N_SEG), .BW(BW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .blink_per_i(blink_per_i),
  .frame_end_i(frame_end_i),
  .seg_map_i  (seg_map_i),
  .seg_o      (seg_o),
  .phase_o    (phase_o),
  .user_q     (user_q),
  .disp_q     (disp_q)
);

// File: tb/sim_lcd_mode_engine.sv
`timescale 1ns/1ps
module sim_lcd_mode_engine;
  localparam int NC = 6;
  localparam int NS = 50;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_com_i = '0;
  logic        wr_hi_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [NS-1:0] seg_map_i = '1;
  logic [2:0]  mode_i = '0;
  logic [7:0]  blink_per_i = '0;
  logic        frame_end_i = 1'b0;
  logic [2:0]  com_sel_i = '0;
  logic [NS-1:0] seg_o;
  logic        phase_o;

  int checks = 0;
  int errors = 0;

  logic [NS-1:0] user_m [NC];
  logic [NS-1:0] disp_m [NC];
  logic          phase_m;
  logic [7:0]    cnt_m;

  always #2.5 clk = ~clk;

  lcd_mode_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_com_i(wr_com_i),
    .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i), .seg_map_i(seg_map_i),
    .mode_i(mode_i), .blink_per_i(blink_per_i), .frame_end_i(frame_end_i),
    .com_sel_i(com_sel_i), .seg_o(seg_o), .phase_o(phase_o)
  );

  function automatic logic [NS-1:0] expect_seg(int c);
    logic [NS-1:0] d, u, p;
    if (c >= NC) return '0;
    d = disp_m[c];
    u = user_m[c];
    case (mode_i)
      3'd0, 3'd6: p = d;
      3'd1:       p = '0;
      3'd2:       p = '1;
      3'd3:       p = phase_m ? d : '0;
      3'd4:       p = ~d;
      3'd5:       p = phase_m ? ~d : '0;
      default:    p = phase_m ? d : u;
    endcase
    return p & seg_map_i;
  endfunction

  task automatic check_all(string req);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      com_sel_i = 3'(c);
      #1;
      checks++;
      if (seg_o !== expect_seg(c)) begin
        errors++;
        $display("FAIL %s mode %0d com %0d seg_o %h expected %h", req, mode_i, c, seg_o, expect_seg(c));
      end
    end
    checks++;
    if (phase_o !== phase_m) begin
      errors++;
      $display("FAIL R7 phase_o %b expected %b", phase_o, phase_m);
    end
  endtask

  task automatic write_word(int com, logic hi, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_com_i = 3'(com); wr_hi_i = hi; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (com < NC) begin
      if (hi) user_m[com][NS-1:32] = d[17:0];
      else    user_m[com][31:0]    = d;
    end
  endtask

  task automatic frame_end();
    @(negedge clk);
    frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
    if (mode_i != 3'd6) for (int c = 0; c < NC; c++) disp_m[c] = user_m[c];
    if (blink_per_i == 0) begin
      cnt_m = 0; phase_m = 1'b1;
    end else if (cnt_m >= blink_per_i) begin
      cnt_m = 0; phase_m = ~phase_m;
    end else begin
      cnt_m = cnt_m + 1'b1;
    end
  endtask

  task automatic fill_random();
    for (int c = 0; c < 8; c++) begin
      write_word(c, 1'b0, $urandom);
      write_word(c, 1'b1, $urandom);
    end
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk);
    mode_i = m;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1357);
    for (int c = 0; c < NC; c++) begin user_m[c] = '0; disp_m[c] = '0; end
    phase_m = 1'b1; cnt_m = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check_all("R1");

    // R2 R3: new data invisible until frame end, index 6/7 ignored
    fill_random();
    check_all("R3");
    frame_end();
    check_all("R2");
    write_word(0, 1'b1, 32'hFFFF_FFFF);
    write_word(2, 1'b0, 32'hA5A5_0F0F);
    frame_end();
    check_all("R2");

    // R5 R6 R11
    set_mode(3'd1); check_all("R5");
    set_mode(3'd2); check_all("R5");
    set_mode(3'd4); check_all("R6");
    set_mode(3'd0); check_all("R11");

    // R4 freeze
    set_mode(3'd6);
    fill_random();
    frame_end();
    check_all("R4");
    frame_end();
    check_all("R4");

    // R9 swap with period 0: display row visible
    set_mode(3'd7);
    check_all("R9");

    // R7 R8 blink
    @(negedge clk); blink_per_i = 8'd2;
    set_mode(3'd3);
    for (int i = 0; i < 7; i++) begin frame_end(); check_all("R8"); end
    set_mode(3'd5);
    for (int i = 0; i < 7; i++) begin frame_end(); check_all("R8"); end
    set_mode(3'd7);
    for (int i = 0; i < 7; i++) begin
      frame_end();
      write_word(i % NC, 1'b0, $urandom);
      check_all("R9");
    end
    @(negedge clk); blink_per_i = 8'd0;
    frame_end(); check_all("R7");

    // R10 map
    @(negedge clk); seg_map_i = {$urandom, $urandom};
    set_mode(3'd2); check_all("R10");
    set_mode(3'd0); check_all("R10");

    // random mix
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 5)
        0: write_word($urandom % 8, 1'($urandom), $urandom);
        1: frame_end();
        2: set_mode(3'($urandom));
        3: begin @(negedge clk); seg_map_i = {$urandom, $urandom}; end
        default: begin @(negedge clk); blink_per_i = 8'($urandom % 4); end
      endcase
      check_all("R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule